// File: doc/BRIEF.md
# Configurable Input Capture Register

This block sits between a group of input pins and the logic behind them. It hands the pin value to internal logic in two ways. The first is a direct path. The second runs through a storage element that a static configuration turns into either an edge-triggered flip-flop or a level-sensitive latch. A selected output carries whichever of the two paths the configuration asks for.

The configuration inputs do four things:

- pick the direct or the stored path for the selected output;
- pick flip-flop or latch behaviour;
- pick the value that the global set/reset loads (cleared or set);
- optionally invert the clock.

A further configuration input states whether the clock enable is wired up. When it is not, the enable counts as always active.

Configuration is meant to stay constant during operation. It is changed only while global set/reset is asserted. Global set/reset is asynchronous and overrides clock, enable and data.

Top module: `pin_capture_reg`

## Requirements
- R1: `in_direct` always equals `pin`. `in_sel` equals `pin` when `cfg_bypass` is 1 and equals `in_reg` when `cfg_bypass` is 0.
- R2: With `cfg_latch` = 0 the stored value changes only at an active clock edge. With `cfg_latch` = 1 it behaves as a latch.
- R3: While `gsr` is 1, `in_reg` equals the set/reset value at once, whatever the clock, enable and pin do. This covers the interval after power-up.
- R4: The set/reset value is all zeros when `cfg_set` is 0 and all ones when `cfg_set` is 1.
- R5: In flip-flop mode without inversion, `pin` is captured on a rising `clk` edge if the enable is effective. With `ce` = 0 (and `cfg_ce_used` = 1), `in_reg` holds.
- R6: With `cfg_ce_used` = 0 the enable is treated as 1 regardless of `ce`.
- R7: In latch mode without inversion, `in_reg` follows `pin` immediately while `clk` is low and the enable is effective. It holds the value present at the rising edge for the whole high phase.
- R8: In latch mode, an ineffective enable keeps `in_reg` unchanged even during the transparent phase.
- R9: With `cfg_clk_inv` = 1, the flip-flop captures on the falling edge and the latch is transparent while `clk` is high.
- R10: After `gsr` falls, `in_reg` keeps the set/reset value until the first capture or transparent phase with an effective enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| ce | input | 1 | Clock enable |
| gsr | input | 1 | Global asynchronous set/reset, active high |
| pin | input | WIDTH | Pin data |
| cfg_bypass | input | 1 | 1: selected output takes the direct path |
| cfg_latch | input | 1 | 1: latch, 0: flip-flop |
| cfg_set | input | 1 | Set/reset value: 1 set, 0 reset |
| cfg_clk_inv | input | 1 | Invert the clock |
| cfg_ce_used | input | 1 | 0: enable treated as always active |
| in_direct | output | WIDTH | Direct pin value |
| in_reg | output | WIDTH | Stored value |
| in_sel | output | WIDTH | Path chosen by configuration |

## Verification
The assertions check the flip-flop on every active edge, for both clock polarities. They confirm that an effective enable loads the sampled pin and that a low enable leaves the stored value stable. They also confirm that the set/reset value is present whenever `gsr` is high.

Latch behaviour can only be shown by the bench scenarios. These cover pin changes that appear mid-phase during transparency and the value frozen at the closing edge. They also cover a low enable blocking a transparent phase, the hold after `gsr` is released, and the selection between the two paths.

// File: rtl/pin_capture_reg.sv
module pin_capture_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             ce,
  input  logic             gsr,
  input  logic [WIDTH-1:0] pin,
  input  logic             cfg_bypass,
  input  logic             cfg_latch,
  input  logic             cfg_set,
  input  logic             cfg_clk_inv,
  input  logic             cfg_ce_used,
  output logic [WIDTH-1:0] in_direct,
  output logic [WIDTH-1:0] in_reg,
  output logic [WIDTH-1:0] in_sel
);

  logic             eclk;
  logic             en;
  logic [WIDTH-1:0] init_val;
  logic [WIDTH-1:0] ff_q;
  logic [WIDTH-1:0] lat_q;

  assign eclk     = clk ^ cfg_clk_inv;
  assign en       = ce | ~cfg_ce_used;
  assign init_val = {WIDTH{cfg_set}};

  always_ff @(posedge eclk or posedge gsr) begin
    if (gsr)     ff_q <= init_val;
    else if (en) ff_q <= pin;
  end

  // transparent while the effective clock is low
  always_latch begin
    if (gsr)               lat_q = init_val;
    else if (!eclk && en)  lat_q = pin;
  end

  assign in_reg    = cfg_latch  ? lat_q : ff_q;
  assign in_direct = pin;
  assign in_sel    = cfg_bypass ? pin   : in_reg;

endmodule

// File: rtl/pin_capture_reg_chk.sv
module pin_capture_reg_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             ce,
  input logic             gsr,
  input logic [WIDTH-1:0] pin,
  input logic             cfg_latch,
  input logic             cfg_set,
  input logic             cfg_clk_inv,
  input logic             cfg_ce_used,
  input logic [WIDTH-1:0] in_reg
);

  always @(negedge clk) begin
    if (gsr) begin
      p_gsr_forces_r3: assert (in_reg == {WIDTH{cfg_set}})
        else $error("set/reset value not held during gsr");
    end
  end

  p_ff_capture_r5: assert property (@(posedge clk) disable iff (gsr)
    (!cfg_latch && !cfg_clk_inv && cfg_ce_used && ce) |=> in_reg == $past(pin))
    else $error("rising-edge capture missed");

  p_ff_hold_r5: assert property (@(posedge clk) disable iff (gsr)
    (!cfg_latch && !cfg_clk_inv && cfg_ce_used && !ce) |=> $stable(in_reg))
    else $error("flip-flop changed with enable low");

  p_ce_default_r6: assert property (@(posedge clk) disable iff (gsr)
    (!cfg_latch && !cfg_clk_inv && !cfg_ce_used) |=> in_reg == $past(pin))
    else $error("unused enable not treated as active");

  p_ff_inv_capture_r9: assert property (@(negedge clk) disable iff (gsr)
    (!cfg_latch && cfg_clk_inv && (ce || !cfg_ce_used)) |=> in_reg == $past(pin))
    else $error("falling-edge capture missed");

endmodule

bind pin_capture_reg pin_capture_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .ce(ce), .gsr(gsr), .pin(pin), .cfg_latch(cfg_latch),
  .cfg_set(cfg_set), .cfg_clk_inv(cfg_clk_inv), .cfg_ce_used(cfg_ce_used),
  .in_reg(in_reg)
);

// File: tb/pin_capture_reg_test.sv
`timescale 1ns/1ps
module pin_capture_reg_test;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         ce = 1'b0, gsr = 1'b0;
  logic [W-1:0] pin = '0;
  logic         cfg_bypass = 1'b0, cfg_latch = 1'b0, cfg_set = 1'b0;
  logic         cfg_clk_inv = 1'b0, cfg_ce_used = 1'b1;
  logic [W-1:0] in_direct, in_reg, in_sel;
  logic [W-1:0] exp_q;
  int vectors = 0, miscompares = 0;

  pin_capture_reg #(.WIDTH(W)) uut (
    .clk(clk), .ce(ce), .gsr(gsr), .pin(pin), .cfg_bypass(cfg_bypass),
    .cfg_latch(cfg_latch), .cfg_set(cfg_set), .cfg_clk_inv(cfg_clk_inv),
    .cfg_ce_used(cfg_ce_used), .in_direct(in_direct), .in_reg(in_reg), .in_sel(in_sel));

  always #4 clk = ~clk;

  function automatic logic en_eff();
    return ce | ~cfg_ce_used;
  endfunction

  function automatic logic [W-1:0] sel_exp();
    return cfg_bypass ? pin : exp_q;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] want);
    vectors++;
    if (act !== want) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, want, $time);
    end
  endtask

  task automatic check_all(string req);
    check(req, in_reg, exp_q);
    check("R1 selected path", in_sel, sel_exp());
    check("R1 direct path", in_direct, pin);
  endtask

  task automatic configure(logic lat, logic inv, logic s, logic used, logic byp);
    @(posedge clk); #1;
    gsr = 1'b1; ce = 1'b1; pin = W'($urandom);
    #0.5 cfg_latch = lat; cfg_clk_inv = inv; cfg_set = s;
    cfg_ce_used = used; cfg_bypass = byp;
    #0.5 gsr = 1'b0;
    #0.5 gsr = 1'b1;
    #0.5 exp_q = {W{s}};
    check_all("R3/R4 set-reset value");
    repeat (2) @(posedge clk);
    #1 pin = W'($urandom);
    #0.5 check_all("R3 priority over clock and enable");
    ce = 1'b0;
    if (inv) begin @(negedge clk); #1; end
    gsr = 1'b0;
    #1 check_all("R10 hold after release");
  endtask

  task automatic ff_step(logic inv);
    if (inv) @(posedge clk); else @(negedge clk);
    #1 pin = W'($urandom); ce = 1'($urandom);
    #1 check_all("R2 no change on inactive edge");
    if (inv) @(negedge clk); else @(posedge clk);
    #1 if (en_eff()) exp_q = pin;
    check_all(inv ? "R9 falling-edge capture" : (cfg_ce_used ? "R5 capture or hold" : "R6 enable default"));
  endtask

  task automatic lat_step(logic inv);
    pin = W'($urandom); ce = 1'($urandom);
    #1 check_all("R7 held while closed");
    if (inv) @(posedge clk); else @(negedge clk);
    #1 if (en_eff()) exp_q = pin;
    check_all(en_eff() ? (inv ? "R9 transparent high" : "R7 transparent") : "R8 enable low hold");
    pin = W'($urandom);
    #1 if (en_eff()) exp_q = pin;
    check_all(en_eff() ? "R7 mid-phase change" : "R8 enable low hold");
    if (inv) @(negedge clk); else @(posedge clk);
    #1;
  endtask

  initial begin
    void'($urandom(32'd20250611));
    #1 gsr = 1'b1;
    #1 exp_q = '0;
    check_all("R3 power-up");
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 2; s++)
        for (int u = 0; u < 2; u++) begin
          configure(m[1], m[0], s[0], ~u[0], 1'($urandom));
          repeat (30) begin
            if (m[1]) lat_step(m[0]);
            else      ff_step(m[0]);
          end
        end
    // directed: bypass in latch mode, enable low, data moves freely
    configure(1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    pin = 4'h5; ce = 1'b0;
    @(negedge clk); #1 check_all("R8 closed enable, all ones kept");
    pin = 4'hA;
    #1 check_all("R1 bypass follows pin");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1000000;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule